// File: doc/BRIEF.md
# Color Line Sensor Black Clamp, Red/Blue Split and Green Alignment

This block sits behind the converters of a two-output color line sensor. Each input beat carries one green sample, one sample of the interleaved red/blue output and the pixel position within the scan line. For each line and each output, the block builds a black reference from a window of eight dark pixels near the start of the line. It removes that reference from the effective pixels and floors the result at zero. It then splits the red/blue stream into separate red and blue samples.

The red/blue output of the sensor trails the green output by two scan lines. To pair each color with the same physical line, the block holds the green data of the last two lines in an internal ring buffer. Green is reduced to one value per red/blue pair before it is stored. The reduction keeps the first green pixel, the second, or their floor average. Each line yields 1024 aligned R, G, B triples. A line-end flag marks the last triple, and a fill flag tells whether the green delay already holds real data.

Top module: `ccd_line_align`

## Requirements
- R1: Pixel positions are 0-based. A line spans positions 0 to 2093, and the effective pixels occupy positions 32 to 2079. Each line produces exactly 1024 pulses of `out_valid`, and two pulses never fall in consecutive cycles.
- R2: The black reference of each output is the sum of its accepted samples at positions 2 to 9 of the current line, shifted right by 3. It applies to the effective pixels of that same line.
- R3: A corrected sample equals the input minus the black reference when the input is larger. Otherwise it is zero.
- R4: For pair k (0 to 1023), `out_r` is the corrected red/blue sample at position 32+2k and `out_b` is the corrected sample at position 33+2k. Both appear in the cycle after the sample at 33+2k is accepted.
- R5: `out_g` of pair k in line L is the reduced green value of pair k in line L-2, counted from reset.
- R6: `g_mode` is sampled when the second sample of a pair is accepted. The codes are 0 for the corrected green at 32+2k, 1 for the corrected green at 33+2k, and 2 or 3 for the floor of the mean of the two.
- R7: `out_last` is high exactly with the `out_valid` pulse of pair 1023.
- R8: `out_filled` is low for every triple of the first two lines after reset. It is high for all later triples and never falls before the next reset.
- R9: A beat with `in_valid` low changes nothing, whatever its other inputs carry. In the following cycle `out_valid` is low.
- R10: During reset `out_valid`, `out_last`, `out_filled`, `out_r` and `out_b` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input beat qualifier |
| in_idx | input | 12 | Pixel position of the beat within the line (0 to 2093) |
| in_g | input | 12 | Green sample |
| in_rb | input | 12 | Interleaved red/blue sample |
| g_mode | input | 2 | Green reduction select |
| out_valid | output | 1 | Triple valid pulse |
| out_r | output | 12 | Corrected red sample |
| out_g | output | 12 | Delayed reduced green sample |
| out_b | output | 12 | Corrected blue sample |
| out_last | output | 1 | Last triple of the line |
| out_filled | output | 1 | Green delay holds data of a real line |

## Verification
A wrong black sum or shift shows on the first triple of the same line, as an offset on every red or blue value near the clamp. A slip in pair parity swaps red and blue right away. A wrong ring-buffer pointer or depth only shows in the third line after reset, as green values from the wrong line or pair. Faults in the line counter show as a misplaced `out_last` or `out_filled` within the first three lines. Random pixel data with random idle gaps between beats, a dark window whose sum is not a multiple of eight, and a line with bright dark pixels that forces heavy clamping bring these faults out quickly.

// File: rtl/ccd_align_pkg.sv
package ccd_align_pkg;

  typedef enum logic [1:0] {
    GSEL_FIRST  = 2'd0,
    GSEL_SECOND = 2'd1,
    GSEL_MEAN   = 2'd2,
    GSEL_MEAN_B = 2'd3
  } gsel_e;

endpackage

// File: rtl/ccd_black_ref.sv
module ccd_black_ref #(
  parameter int unsigned DW      = 12,
  parameter int unsigned IDXW    = 12,
  parameter int unsigned DARK_LO = 2,
  parameter int unsigned DARK_N  = 8,
  localparam int unsigned SHIFT  = $clog2(DARK_N),
  localparam int unsigned SW     = DW + SHIFT,
  localparam int unsigned DARK_HI = DARK_LO + DARK_N - 1
) (
  input  logic            clk,
  input  logic            rst_l,
  input  logic            smp_en,
  input  logic [IDXW-1:0] idx,
  input  logic [DW-1:0]   smp,
  output logic [DW-1:0]   ref_o
);

  logic [SW-1:0] sum_q, sum_d, acc;
  logic [DW-1:0] ref_q, ref_d;
  logic          in_win, win_first, win_last;

  assign in_win    = (idx >= IDXW'(DARK_LO)) && (idx <= IDXW'(DARK_HI));
  assign win_first = (idx == IDXW'(DARK_LO));
  assign win_last  = (idx == IDXW'(DARK_HI));

  always_comb begin
    acc   = win_first ? SW'(smp) : (sum_q + SW'(smp));
    sum_d = sum_q;
    ref_d = ref_q;
    if (smp_en && in_win) begin
      sum_d = acc;
      if (win_last) ref_d = DW'(acc >> SHIFT);
    end
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      sum_q <= '0;
      ref_q <= '0;
    end else begin
      sum_q <= sum_d;
      ref_q <= ref_d;
    end
  end

  assign ref_o = ref_q;

endmodule

// File: rtl/ccd_green_delay.sv
module ccd_green_delay #(
  parameter int unsigned DW    = 12,
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_l,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_q;
  logic [AW-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (wr_en) ptr_d = (ptr_q == AW'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  // read-first ring: the word read is the one written DEPTH writes earlier
  always_ff @(posedge clk) begin
    if (wr_en) begin
      rd_q       <= mem[ptr_q];
      mem[ptr_q] <= wr_data;
    end
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/ccd_line_align.sv
module ccd_line_align
  import ccd_align_pkg::*;
#(
  parameter int unsigned DW       = 12,
  parameter int unsigned LINE_LEN = 2094,
  parameter int unsigned LEAD     = 32,
  parameter int unsigned EFF      = 2048,
  parameter int unsigned DARK_LO  = 2,
  parameter int unsigned DARK_N   = 8,
  localparam int unsigned IDXW    = $clog2(LINE_LEN),
  localparam int unsigned PAIRS   = EFF / 2,
  localparam int unsigned EFF_END = LEAD + EFF - 1,
  localparam int unsigned LAG     = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [IDXW-1:0] in_idx,
  input  logic [DW-1:0]   in_g,
  input  logic [DW-1:0]   in_rb,
  input  logic [1:0]      g_mode,
  output logic            out_valid,
  output logic [DW-1:0]   out_r,
  output logic [DW-1:0]   out_g,
  output logic [DW-1:0]   out_b,
  output logic            out_last,
  output logic            out_filled
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_l = rs_q[1];

  function automatic logic [DW-1:0] sub_clamp(input logic [DW-1:0] a,
                                              input logic [DW-1:0] r);
    return (a > r) ? (a - r) : '0;
  endfunction

  // black references, index 0 green, index 1 red/blue
  logic [DW-1:0] chan_smp [2];
  logic [DW-1:0] chan_ref [2];
  assign chan_smp[0] = in_g;
  assign chan_smp[1] = in_rb;

  for (genvar c = 0; c < 2; c++) begin : g_ref
    ccd_black_ref #(
      .DW(DW), .IDXW(IDXW), .DARK_LO(DARK_LO), .DARK_N(DARK_N)
    ) u_ref (
      .clk   (clk),
      .rst_l (rst_l),
      .smp_en(in_valid),
      .idx   (in_idx),
      .smp   (chan_smp[c]),
      .ref_o (chan_ref[c])
    );
  end

  // position decode
  logic [IDXW-1:0] off;
  logic            in_eff, first_fire, pair_fire, last_pair;
  logic [DW-1:0]   g_cor, rb_cor;

  assign off        = in_idx - IDXW'(LEAD);
  assign in_eff     = (in_idx >= IDXW'(LEAD)) && (in_idx <= IDXW'(EFF_END));
  assign first_fire = in_valid && in_eff && !off[0];
  assign pair_fire  = in_valid && in_eff && off[0];
  assign last_pair  = (off == IDXW'(EFF - 1));
  assign g_cor      = sub_clamp(in_g, chan_ref[0]);
  assign rb_cor     = sub_clamp(in_rb, chan_ref[1]);

  // first half of a pair
  logic [DW-1:0] hold_r_q, hold_r_d, hold_g_q, hold_g_d;

  always_comb begin
    hold_r_d = hold_r_q;
    hold_g_d = hold_g_q;
    if (first_fire) begin
      hold_r_d = rb_cor;
      hold_g_d = g_cor;
    end
  end

  // green reduction
  gsel_e         gsel;
  logic [DW-1:0] g_red;

  assign gsel = gsel_e'(g_mode);

  always_comb begin
    unique case (gsel)
      GSEL_FIRST:  g_red = hold_g_q;
      GSEL_SECOND: g_red = g_cor;
      default:     g_red = DW'(({1'b0, hold_g_q} + {1'b0, g_cor}) >> 1);
    endcase
  end

  ccd_green_delay #(.DW(DW), .DEPTH(LAG * PAIRS)) u_gdly (
    .clk    (clk),
    .rst_l  (rst_l),
    .wr_en  (pair_fire),
    .wr_data(g_red),
    .rd_data(out_g)
  );

  // line counter and output registers
  logic [1:0]    lines_q, lines_d;
  logic          vld_q, vld_d, last_q, last_d, fill_q, fill_d;
  logic [DW-1:0] r_q, r_d, b_q, b_d;

  always_comb begin
    lines_d = lines_q;
    vld_d   = pair_fire;
    last_d  = pair_fire && last_pair;
    fill_d  = fill_q;
    r_d     = r_q;
    b_d     = b_q;
    if (pair_fire) begin
      r_d = hold_r_q;
      b_d = rb_cor;
      if (lines_q == 2'(LAG)) fill_d = 1'b1;
      if (last_pair && (lines_q != 2'(LAG))) lines_d = lines_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      hold_r_q <= '0;
      hold_g_q <= '0;
      lines_q  <= '0;
      vld_q    <= 1'b0;
      last_q   <= 1'b0;
      fill_q   <= 1'b0;
      r_q      <= '0;
      b_q      <= '0;
    end else begin
      hold_r_q <= hold_r_d;
      hold_g_q <= hold_g_d;
      lines_q  <= lines_d;
      vld_q    <= vld_d;
      last_q   <= last_d;
      fill_q   <= fill_d;
      r_q      <= r_d;
      b_q      <= b_d;
    end
  end

  assign out_valid  = vld_q;
  assign out_r      = r_q;
  assign out_b      = b_q;
  assign out_last   = last_q;
  assign out_filled = fill_q;

endmodule

// File: rtl/ccd_line_align_chk.sv
module ccd_line_align_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic out_valid,
  input logic out_last,
  input logic out_filled
);

  assert_no_back_to_back_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_valid_follows_beat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  assert_last_with_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  assert_filled_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(out_filled));

  assert_idle_beat_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

endmodule

bind ccd_line_align ccd_line_align_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_last  (out_last),
  .out_filled(out_filled)
);

// File: tb/tb_ccd_line_align.sv
module tb_ccd_line_align;

  localparam int CLK_PERIOD = 10;
  localparam int DW    = 12;
  localparam int LINE  = 2094;
  localparam int LEAD  = 32;
  localparam int PAIRS = 1024;
  localparam int MAXV  = (1 << DW) - 1;

  logic          clk, rst_n, in_valid;
  logic [11:0]   in_idx;
  logic [DW-1:0] in_g, in_rb;
  logic [1:0]    g_mode;
  logic          out_valid, out_last, out_filled;
  logic [DW-1:0] out_r, out_g, out_b;

  ccd_line_align dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_idx(in_idx),
    .in_g(in_g), .in_rb(in_rb), .g_mode(g_mode), .out_valid(out_valid),
    .out_r(out_r), .out_g(out_g), .out_b(out_b), .out_last(out_last),
    .out_filled(out_filled)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  int ln_g [LINE];
  int ln_rb [LINE];
  int exp_r [PAIRS];
  int exp_b [PAIRS];
  int exp_g [PAIRS];
  int gs_hist [3][PAIRS];
  bit exp_fill;
  bit mon_on = 0;
  int mon_cnt;
  int cur_line = 0;
  bit iv_seen;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int csub(input int a, input int r);
    return (a > r) ? a - r : 0;
  endfunction

  function automatic int gred(input int a, input int b, input int m);
    if (m == 0) return a;
    if (m == 1) return b;
    return (a + b) / 2;
  endfunction

  // kind 0: random, 1: bright dark window (clamping), 2: dark sum not a multiple of 8
  task automatic build_line(input int kind, input int mode);
    int bg, brb;
    for (int i = 0; i < LINE; i++) begin
      ln_g[i]  = $urandom_range(MAXV, 0);
      ln_rb[i] = $urandom_range(MAXV, 0);
      if (i >= 2 && i <= 9) begin
        if (kind == 1) begin
          ln_g[i]  = $urandom_range(MAXV, 3000);
          ln_rb[i] = $urandom_range(MAXV, 3000);
        end else if (kind == 2) begin
          ln_g[i]  = i + 1 + ((i == 9) ? 2 : 0);
          ln_rb[i] = 2 * i + ((i == 2) ? 5 : 0);
        end else begin
          ln_g[i]  = $urandom_range(255, 0);
          ln_rb[i] = $urandom_range(255, 0);
        end
      end
    end
    bg = 0; brb = 0;
    for (int i = 2; i <= 9; i++) begin
      bg  += ln_g[i];
      brb += ln_rb[i];
    end
    bg = bg >> 3; brb = brb >> 3;
    for (int k = 0; k < PAIRS; k++) begin
      exp_r[k] = csub(ln_rb[LEAD + 2*k], brb);
      exp_b[k] = csub(ln_rb[LEAD + 2*k + 1], brb);
      gs_hist[cur_line % 3][k] = gred(csub(ln_g[LEAD + 2*k], bg),
                                      csub(ln_g[LEAD + 2*k + 1], bg), mode);
      exp_g[k] = (cur_line >= 2) ? gs_hist[(cur_line + 1) % 3][k] : 0;
    end
    exp_fill = (cur_line >= 2);
  endtask

  task automatic idle_beat();
    @(posedge clk); #1;
    in_valid = 1'b0;
    in_idx   = 12'($urandom_range(LINE - 1, 0));
    in_g     = DW'($urandom);
    in_rb    = DW'($urandom);
  endtask

  task automatic run_line(input int kind, input int mode, input bit gaps);
    build_line(kind, mode);
    g_mode  = 2'(mode);
    mon_cnt = 0;
    for (int i = 0; i < LINE; i++) begin
      while (gaps && ($urandom_range(7, 0) == 0)) idle_beat();
      @(posedge clk); #1;
      in_valid = 1'b1;
      in_idx   = 12'(i);
      in_g     = DW'(ln_g[i]);
      in_rb    = DW'(ln_rb[i]);
    end
    for (int j = 0; j < 3; j++) idle_beat();
    check(mon_cnt == PAIRS, "R1", "triples per line", mon_cnt, PAIRS);
    cur_line++;
  endtask

  always @(posedge clk) iv_seen <= in_valid;

  always @(negedge clk) begin
    if (mon_on) begin
      if (!iv_seen) check(out_valid == 1'b0, "R9", "out_valid after idle beat", out_valid, 0);
      if (out_valid) begin
        if (mon_cnt < PAIRS) begin
          check(out_r == DW'(exp_r[mon_cnt]), "R4/R3/R2", "out_r", out_r, exp_r[mon_cnt]);
          check(out_b == DW'(exp_b[mon_cnt]), "R4/R3/R2", "out_b", out_b, exp_b[mon_cnt]);
          if (exp_fill)
            check(out_g == DW'(exp_g[mon_cnt]), "R5/R6", "out_g", out_g, exp_g[mon_cnt]);
          check(out_filled == exp_fill, "R8", "out_filled", out_filled, exp_fill);
          check(out_last == (mon_cnt == PAIRS - 1), "R7", "out_last", out_last,
                (mon_cnt == PAIRS - 1));
        end
        mon_cnt++;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; in_valid = 1'b0; in_idx = '0; in_g = '0; in_rb = '0; g_mode = '0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(out_valid == 0, "R10", "reset out_valid", out_valid, 0);
    check(out_last == 0, "R10", "reset out_last", out_last, 0);
    check(out_filled == 0, "R10", "reset out_filled", out_filled, 0);
    check(out_r == 0, "R10", "reset out_r", out_r, 0);
    check(out_b == 0, "R10", "reset out_b", out_b, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (4) idle_beat();
    mon_on = 1'b1;
    run_line(0, 0, 1'b0);
    run_line(0, 1, 1'b1);
    run_line(2, 2, 1'b0);   // R2 floor of non-multiple sum
    run_line(1, 3, 1'b1);   // R3 heavy clamping
    run_line(0, 0, 1'b1);
    run_line(2, 1, 1'b0);
    run_line(0, 2, 1'b1);
    run_line(1, 0, 1'b0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule